// File: doc/BRIEF.md
# Statically Scheduled Tile Crossbar Router

This block is the communication interface of one tile in a mesh. It joins four neighbour links (north, south, east, west) and the local core through a 5x5 crossbar. Routing is not decided from packet headers. A program counter steps through a stored list of crossbar settings, one setting per clock slot, and then starts the list again. Data moves one hop per scheduled slot, so a transfer across the mesh passes through several tiles in turn.

The schedule memory has two banks, and each bank holds one schedule. Each bank has a base register that gives the slot where its schedule starts. A configuration request selects the other bank. The router changes to it only when the running schedule wraps, so a pass through the schedule is never cut off part way. The core attaches through two small queues with valid/ready handshakes. A slot that cannot be served on the core side is dropped and flagged, and the schedule keeps running.

Configuration uses one strobe with an operation code. Schedule words and base values can be written while the router is halted, or into the bank that is not active while it runs. `runEn` starts and stops the schedule.

Top module: `tileRouter`

## Requirements
- R1: After reset the router is halted and bank 0 is active. All `linkOutValid` bits are 0, `coreOutValid` is 0, `coreInReady` is 1 and `coreBlocked` is 0. Every schedule word resets to "no source" on every output, with the end flag clear.
- R2: A schedule word is 16 bits. Output p (0 = north, 1 = south, 2 = east, 3 = west, 4 = core) takes its source select from bits [3p+2:3p]. Source codes are 0 north, 1 south, 2 east, 3 west and 4 core. Codes 5 to 7 mean no source. Bit 15 is the end-of-schedule flag.
- R3: In a running slot, a neighbour output whose select names a neighbour drives that input's data with its valid bit set. Output registers make this visible one clock later. A select of "no source" clears the valid bit. One source may feed several outputs in the same slot.
- R4: After a slot whose word has the end flag set, the next slot reads the active bank's base slot. Otherwise the next slot is pc+1, and the count wraps from the last slot of the bank to slot 0.
- R5: With `runEn` high, the halted router spends one load cycle. During that cycle it makes the requested bank active and loads the PC from that bank's base register. Slots run from the next cycle on.
- R6: A switch request (op 2, `cfgData[0]` names the bank) changes the active bank only at the next wrap caused by the end flag, or at the next start. Slots without the end flag leave `activeSched` unchanged.
- R7: When any output selects the core in a slot and the core input queue holds data, exactly one entry is removed. It is delivered to every output that selects the core.
- R8: When any output selects the core and the core input queue is empty, those outputs carry no valid data. `coreBlocked` is 1 in the following cycle, and the schedule continues.
- R9: When the core output selects a source and the core output queue is full, the word is dropped and `coreBlocked` is 1 in the following cycle.
- R10: A word write (op 0, `cfgAddr` = {bank, slot}) or a base write (op 1, bank = `cfgAddr` MSB, value = `cfgData` low bits) takes effect when the router is halted, or when it is running and the bank is not the active one. Otherwise it is ignored.
- R11: Each core queue is first-in first-out and holds `QUEUE_DEPTH` entries. `coreInReady` is low exactly when the input queue is full, and `coreOutValid` is high exactly when the output queue holds data.
- R12: With `runEn` low, no slot executes. In the following cycle every `linkOutValid` bit is 0, `coreBlocked` is 0, and neither queue gains or loses an entry through the crossbar.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | High to run the schedule, low to halt |
| cfgWrEn | input | 1 | Configuration strobe |
| cfgOp | input | 2 | 0 word write, 1 base write, 2 switch request, 3 no operation |
| cfgAddr | input | SLOT_AW+1 | Bank (MSB) and slot of a configuration write |
| cfgData | input | 16 | Schedule word, base value or bank select |
| linkIn | input | 4*DATA_W | Neighbour inputs, north in the low lane, then south, east, west |
| linkOut | output | 4*DATA_W | Neighbour outputs, in the same lane order |
| linkOutValid | output | 4 | One valid bit per neighbour output |
| coreInData | input | DATA_W | Data from the core |
| coreInValid | input | 1 | Core offers data |
| coreInReady | output | 1 | Core input queue has room |
| coreOutData | output | DATA_W | Head of the core output queue |
| coreOutValid | output | 1 | Core output queue holds data |
| coreOutReady | input | 1 | Core takes the head entry |
| coreBlocked | output | 1 | Previous slot dropped a core-side transfer |
| activeSched | output | 1 | Bank currently being run |

## Verification
The queue properties assume that the datapath asks for a write only when a queue has room and for a read only when it holds data. The stimulus keeps the core side busy and stalls each direction in turn, so the full and empty edges are reached often. The write-guard and switch properties assume that the active bank changes only through the controller's load or end-of-schedule path. The bench therefore sends switch requests in the middle of schedules and writes into the active bank while the router runs. Inputs change only on the falling clock edge, so every property samples stable values. The reference model tracks the same pre-edge state that the properties rely on.

// File: rtl/tileRouterPkg.sv
`timescale 1ns/1ps
package tileRouterPkg;
  localparam int NUM_LINKS = 4;
  localparam int NUM_PORTS = NUM_LINKS + 1;
  localparam int SEL_W     = 3;
  localparam int WORD_W    = NUM_PORTS * SEL_W + 1;

  typedef enum logic [2:0] {
    SRC_NORTH = 3'd0,
    SRC_SOUTH = 3'd1,
    SRC_EAST  = 3'd2,
    SRC_WEST  = 3'd3,
    SRC_CORE  = 3'd4,
    SRC_NONE  = 3'd7
  } srcSel_e;

  typedef enum logic [1:0] {ST_HALT, ST_LOAD, ST_RUN} ctrlState_e;

  typedef enum logic [1:0] {
    OP_WORD   = 2'd0,
    OP_BASE   = 2'd1,
    OP_SWITCH = 2'd2,
    OP_NOP    = 2'd3
  } cfgOp_e;

  typedef struct packed {
    logic slotEn;
    logic wordWe;
  } ctrlStrobes_t;
endpackage

// File: rtl/coreQueue.sv
`timescale 1ns/1ps
module coreQueue #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  input  logic         rdEn,
  output logic [W-1:0] rdData,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;

  assign rdData = store[rdPtr];
  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrEn) begin
        store[wrPtr] <= wrData;
        wrPtr        <= bump(wrPtr);
      end
      if (rdEn) rdPtr <= bump(rdPtr);
      if (wrEn && !rdEn)      count <= count + 1'b1;
      else if (!wrEn && rdEn) count <= count - 1'b1;
    end
  end

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rstN) wrEn |-> !full);  // R11
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN) rdEn |-> !empty); // R11
endmodule

// File: rtl/routerCtrl.sv
`timescale 1ns/1ps
module routerCtrl import tileRouterPkg::*; #(
  parameter int SLOT_AW = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               runEn,
  input  logic               cfgWrEn,
  input  logic [1:0]         cfgOp,
  input  logic [SLOT_AW:0]   cfgAddr,
  input  logic [SLOT_AW-1:0] cfgValue,
  input  logic               slotEnd,
  output ctrlStrobes_t       strobes,
  output logic [SLOT_AW:0]   rdAddr,
  output logic               activeSched
);
  ctrlState_e         state;
  logic [SLOT_AW-1:0] pc;
  logic [SLOT_AW-1:0] baseReg [2];
  logic               targetSched;
  logic               cfgBank;
  logic               bankOk;

  assign cfgBank = cfgAddr[SLOT_AW];
  assign bankOk  = (state == ST_HALT) || ((state == ST_RUN) && (cfgBank != activeSched));
  assign strobes.slotEn = (state == ST_RUN) && runEn;
  assign strobes.wordWe = cfgWrEn && (cfgOp == OP_WORD) && bankOk;
  assign rdAddr = {activeSched, pc};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_HALT;
      pc          <= '0;
      baseReg[0]  <= '0;
      baseReg[1]  <= '0;
      activeSched <= 1'b0;
      targetSched <= 1'b0;
    end else begin
      unique case (state)
        ST_HALT: if (runEn) state <= ST_LOAD;
        ST_LOAD: begin
          activeSched <= targetSched;
          pc          <= baseReg[targetSched];
          state       <= ST_RUN;
        end
        default: begin
          if (!runEn) state <= ST_HALT;
          else if (slotEnd) begin
            activeSched <= targetSched;
            pc          <= baseReg[targetSched];
          end else pc <= pc + 1'b1;
        end
      endcase
      if (cfgWrEn && (cfgOp == OP_BASE) && bankOk) baseReg[cfgBank] <= cfgValue;
      if (cfgWrEn && (cfgOp == OP_SWITCH))          targetSched      <= cfgValue[0];
    end
  end

  AST_WRITE_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wordWe && state != ST_HALT) |-> (cfgAddr[SLOT_AW] != activeSched)); // R10
  AST_SWITCH_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.slotEn && !slotEnd) |=> $stable(activeSched)); // R6
endmodule

// File: rtl/routerDatapath.sv
`timescale 1ns/1ps
module routerDatapath import tileRouterPkg::*; #(
  parameter int DATA_W      = 16,
  parameter int SLOT_AW     = 3,
  parameter int QUEUE_DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobes_t                  strobes,
  input  logic [SLOT_AW:0]              wrAddr,
  input  logic [WORD_W-1:0]             wrData,
  input  logic [SLOT_AW:0]              rdAddr,
  input  logic [NUM_LINKS*DATA_W-1:0]   linkIn,
  output logic [NUM_LINKS*DATA_W-1:0]   linkOut,
  output logic [NUM_LINKS-1:0]          linkOutValid,
  input  logic [DATA_W-1:0]             coreInData,
  input  logic                          coreInValid,
  output logic                          coreInReady,
  output logic [DATA_W-1:0]             coreOutData,
  output logic                          coreOutValid,
  input  logic                          coreOutReady,
  output logic                          coreBlocked,
  output logic                          slotEnd
);
  localparam int MEM_DEPTH = 2 ** (SLOT_AW + 1);
  localparam logic [WORD_W-1:0] IDLE_WORD = {1'b0, {NUM_PORTS{3'b111}}};

  logic [WORD_W-1:0] schedMem [MEM_DEPTH];
  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] srcData [8];
  logic [DATA_W-1:0] inHead;
  logic [DATA_W-1:0] nextData [NUM_LINKS];
  logic [NUM_LINKS-1:0] nextValid;
  logic [SEL_W-1:0]  coreSel;
  logic inEmpty, inFull, outEmpty, outFull;
  logic anyCoreSrc, coreDestWant, coreSrcOk, inPop, outPush, blockNext;

  assign word    = schedMem[rdAddr];
  assign slotEnd = word[WORD_W-1];

  for (genvar s = 0; s < 8; s++) begin : g_src
    if (s < NUM_LINKS) begin : g_link_src
      assign srcData[s] = linkIn[s*DATA_W +: DATA_W];
    end else if (s == NUM_LINKS) begin : g_core_src
      assign srcData[s] = inHead;
    end else begin : g_none_src
      assign srcData[s] = '0;
    end
  end

  always_comb begin
    anyCoreSrc = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (word[p*SEL_W +: SEL_W] == SRC_CORE) anyCoreSrc = 1'b1;
  end

  for (genvar o = 0; o < NUM_LINKS; o++) begin : g_link
    logic [SEL_W-1:0] sel;
    assign sel          = word[o*SEL_W +: SEL_W];
    assign nextValid[o] = strobes.slotEn && ((sel < 3'd4) || ((sel == SRC_CORE) && !inEmpty));
    assign nextData[o]  = srcData[sel];
  end

  assign coreSel      = word[NUM_LINKS*SEL_W +: SEL_W];
  assign coreDestWant = strobes.slotEn && (coreSel <= SRC_CORE);
  assign coreSrcOk    = (coreSel != SRC_CORE) || !inEmpty;
  assign outPush      = coreDestWant && coreSrcOk && !outFull;
  assign inPop        = strobes.slotEn && anyCoreSrc && !inEmpty;
  assign blockNext    = (strobes.slotEn && anyCoreSrc && inEmpty) ||
                        (coreDestWant && coreSrcOk && outFull);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linkOutValid <= '0;
      linkOut      <= '0;
      coreBlocked  <= 1'b0;
    end else begin
      linkOutValid <= nextValid;
      coreBlocked  <= blockNext;
      for (int o = 0; o < NUM_LINKS; o++) linkOut[o*DATA_W +: DATA_W] <= nextData[o];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_DEPTH; i++) schedMem[i] <= IDLE_WORD;
    end else if (strobes.wordWe) begin
      schedMem[wrAddr] <= wrData;
    end
  end

  coreQueue #(.W(DATA_W), .DEPTH(QUEUE_DEPTH)) inQueue (
    .clk(clk), .rstN(rstN),
    .wrEn(coreInValid && !inFull), .wrData(coreInData),
    .rdEn(inPop), .rdData(inHead), .empty(inEmpty), .full(inFull)
  );

  coreQueue #(.W(DATA_W), .DEPTH(QUEUE_DEPTH)) outQueue (
    .clk(clk), .rstN(rstN),
    .wrEn(outPush), .wrData(srcData[coreSel]),
    .rdEn(coreOutReady && !outEmpty), .rdData(coreOutData), .empty(outEmpty), .full(outFull)
  );

  assign coreInReady  = !inFull;
  assign coreOutValid = !outEmpty;

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.slotEn |=> ((linkOutValid == '0) && !coreBlocked)); // R12
endmodule

// File: rtl/tileRouter.sv
`timescale 1ns/1ps
module tileRouter import tileRouterPkg::*; #(
  parameter int DATA_W      = 16,
  parameter int SLOT_AW     = 3,
  parameter int QUEUE_DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        runEn,
  input  logic                        cfgWrEn,
  input  logic [1:0]                  cfgOp,
  input  logic [SLOT_AW:0]            cfgAddr,
  input  logic [WORD_W-1:0]           cfgData,
  input  logic [NUM_LINKS*DATA_W-1:0] linkIn,
  output logic [NUM_LINKS*DATA_W-1:0] linkOut,
  output logic [NUM_LINKS-1:0]        linkOutValid,
  input  logic [DATA_W-1:0]           coreInData,
  input  logic                        coreInValid,
  output logic                        coreInReady,
  output logic [DATA_W-1:0]           coreOutData,
  output logic                        coreOutValid,
  input  logic                        coreOutReady,
  output logic                        coreBlocked,
  output logic                        activeSched
);
  ctrlStrobes_t     strobes;
  logic [SLOT_AW:0] rdAddr;
  logic             slotEnd;

  routerCtrl #(.SLOT_AW(SLOT_AW)) ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn),
    .cfgWrEn(cfgWrEn), .cfgOp(cfgOp), .cfgAddr(cfgAddr),
    .cfgValue(cfgData[SLOT_AW-1:0]), .slotEnd(slotEnd),
    .strobes(strobes), .rdAddr(rdAddr), .activeSched(activeSched)
  );

  routerDatapath #(.DATA_W(DATA_W), .SLOT_AW(SLOT_AW), .QUEUE_DEPTH(QUEUE_DEPTH)) datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrAddr(cfgAddr), .wrData(cfgData), .rdAddr(rdAddr),
    .linkIn(linkIn), .linkOut(linkOut), .linkOutValid(linkOutValid),
    .coreInData(coreInData), .coreInValid(coreInValid), .coreInReady(coreInReady),
    .coreOutData(coreOutData), .coreOutValid(coreOutValid), .coreOutReady(coreOutReady),
    .coreBlocked(coreBlocked), .slotEnd(slotEnd)
  );
endmodule

// File: tb/tileRouter_test.sv
`timescale 1ns/1ps
module tileRouter_test;
  localparam int DW = 16;
  localparam int QD = 4;

  logic clk = 0;
  logic rstN = 0;
  logic runEn = 0, cfgWrEn = 0;
  logic [1:0] cfgOp = 2'd3;
  logic [3:0] cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic [4*DW-1:0] linkIn = '0;
  logic [4*DW-1:0] linkOut;
  logic [3:0] linkOutValid;
  logic [DW-1:0] coreInData = '0, coreOutData;
  logic coreInValid = 0, coreInReady, coreOutValid, coreOutReady = 0;
  logic coreBlocked, activeSched;

  int checks = 0, failures = 0;
  string phase = "R1";
  bit feed = 0, drain = 0;

  always #2.5 clk = ~clk;

  tileRouter uut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .cfgWrEn(cfgWrEn), .cfgOp(cfgOp),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .linkIn(linkIn), .linkOut(linkOut),
    .linkOutValid(linkOutValid), .coreInData(coreInData), .coreInValid(coreInValid),
    .coreInReady(coreInReady), .coreOutData(coreOutData), .coreOutValid(coreOutValid),
    .coreOutReady(coreOutReady), .coreBlocked(coreBlocked), .activeSched(activeSched)
  );

  // Reference model state
  logic [15:0] mMem [16];
  int mBase [2];
  int mState = 0, mPc = 0, mActive = 0, mTarget = 0;
  logic [DW-1:0] inQ[$], outQ[$];
  bit eValid [4];
  logic [DW-1:0] eData [4];
  bit eBlocked = 0;

  function automatic int fld(logic [15:0] w, int p);
    return int'((w >> (3 * p)) & 16'h7);
  endfunction

  function automatic logic [15:0] mk(logic [2:0] n, logic [2:0] s, logic [2:0] e,
                                     logic [2:0] w, logic [2:0] c, logic en);
    return {en, c, w, e, s, n};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mPc = 0; mActive = 0; mTarget = 0; mBase[0] = 0; mBase[1] = 0;
      for (int i = 0; i < 16; i++) mMem[i] = 16'h7FFF;
      inQ.delete(); outQ.delete();
      for (int o = 0; o < 4; o++) begin eValid[o] = 0; eData[o] = '0; end
      eBlocked = 0;
    end else begin
      logic [15:0] word;
      bit slot, inEmpty, outFull, anyCore, blk, doPush, bankOk;
      logic [DW-1:0] head, pv;
      int fc, inSize0, newTarget;
      word = mMem[mActive * 8 + mPc];
      slot = (mState == 2) && runEn;
      inSize0 = inQ.size();
      inEmpty = (inSize0 == 0);
      outFull = (outQ.size() == QD);
      head = inEmpty ? '0 : inQ[0];
      anyCore = 0; blk = 0; doPush = 0; pv = '0;
      for (int p = 0; p < 5; p++) if (fld(word, p) == 4) anyCore = 1;
      for (int o = 0; o < 4; o++) begin
        int f;
        f = fld(word, o);
        if (slot && f < 4) begin eValid[o] = 1; eData[o] = linkIn[f*DW +: DW]; end
        else if (slot && f == 4 && !inEmpty) begin eValid[o] = 1; eData[o] = head; end
        else eValid[o] = 0;
      end
      if (slot && anyCore && inEmpty) blk = 1;
      fc = fld(word, 4);
      if (slot && fc <= 4) begin
        if (fc == 4 && inEmpty) ;
        else if (outFull) blk = 1;
        else begin doPush = 1; pv = (fc == 4) ? head : linkIn[fc*DW +: DW]; end
      end
      eBlocked = blk;
      if (outQ.size() > 0 && coreOutReady) void'(outQ.pop_front());
      if (doPush) outQ.push_back(pv);
      if (slot && anyCore && !inEmpty) void'(inQ.pop_front());
      if (coreInValid && inSize0 < QD) inQ.push_back(coreInData);
      bankOk = (mState == 0) || (mState == 2 && int'(cfgAddr[3]) != mActive);
      newTarget = mTarget;
      if (cfgWrEn && cfgOp == 2'd2) newTarget = int'(cfgData[0]);
      case (mState)
        0: if (runEn) mState = 1;
        1: begin mActive = mTarget; mPc = mBase[mTarget]; mState = 2; end
        default: begin
          if (!runEn) mState = 0;
          else if (word[15]) begin mActive = mTarget; mPc = mBase[mTarget]; end
          else mPc = (mPc + 1) % 8;
        end
      endcase
      if (cfgWrEn && cfgOp == 2'd0 && bankOk) mMem[cfgAddr] = cfgData;
      if (cfgWrEn && cfgOp == 2'd1 && bankOk) mBase[cfgAddr[3]] = int'(cfgData[2:0]);
      mTarget = newTarget;
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  task automatic compareAll();
    for (int o = 0; o < 4; o++) begin
      chk($sformatf("linkOutValid[%0d]", o), 32'(linkOutValid[o]), 32'(eValid[o]));
      if (eValid[o]) chk($sformatf("linkOut[%0d]", o), 32'(linkOut[o*DW +: DW]), 32'(eData[o]));
    end
    chk("coreBlocked", 32'(coreBlocked), 32'(eBlocked));
    chk("coreOutValid", 32'(coreOutValid), 32'(outQ.size() > 0));
    if (outQ.size() > 0) chk("coreOutData", 32'(coreOutData), 32'(outQ[0]));
    chk("coreInReady", 32'(coreInReady), 32'(inQ.size() < QD));
    chk("activeSched", 32'(activeSched), 32'(mActive));
  endtask

  task automatic tick();
    @(negedge clk);
    compareAll();
    linkIn = {$urandom, $urandom};
    coreInData = DW'($urandom);
    coreInValid = feed ? 1'($urandom % 2) : 1'b0;
    coreOutReady = drain ? 1'($urandom % 2) : 1'b0;
  endtask

  task automatic cfgWrite(logic [1:0] op, logic [3:0] addr, logic [15:0] data);
    cfgWrEn = 1; cfgOp = op; cfgAddr = addr; cfgData = data;
    tick();
    cfgWrEn = 0; cfgOp = 2'd3;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    phase = "R1";
    chk("linkOutValid", 32'(linkOutValid), 32'h0);
    chk("coreOutValid", 32'(coreOutValid), 32'h0);
    chk("coreInReady", 32'(coreInReady), 32'h1);
    chk("coreBlocked", 32'(coreBlocked), 32'h0);
    chk("activeSched", 32'(activeSched), 32'h0);
    run(2);
    // R10/R2: load both banks while halted
    phase = "R10";
    cfgWrite(2'd0, 4'd0, mk(3'd1, 3'd0, 3'd3, 3'd2, 3'd7, 1'b0));
    cfgWrite(2'd0, 4'd1, mk(3'd4, 3'd7, 3'd4, 3'd7, 3'd0, 1'b0));
    cfgWrite(2'd0, 4'd2, mk(3'd7, 3'd7, 3'd7, 3'd4, 3'd4, 1'b0));
    cfgWrite(2'd0, 4'd8, mk(3'd3, 3'd3, 3'd3, 3'd3, 3'd3, 1'b1));
    cfgWrite(2'd0, 4'd10, mk(3'd2, 3'd2, 3'd5, 3'd6, 3'd7, 1'b0));
    cfgWrite(2'd0, 4'd11, mk(3'd7, 3'd7, 3'd1, 3'd7, 3'd3, 1'b1));
    cfgWrite(2'd1, 4'd8, 16'd2);
    phase = "R12"; feed = 1;
    run(12);
    phase = "R5"; runEn = 1;
    run(4);
    phase = "R2"; drain = 1;
    run(20);
    phase = "R3";
    run(20);
    phase = "R7";
    run(20);
    phase = "R4";
    run(20);
    phase = "R8"; feed = 0;
    run(30);
    phase = "R9"; feed = 1; drain = 0;
    run(30);
    phase = "R11"; drain = 1;
    run(30);
    phase = "R10";
    cfgWrite(2'd0, 4'd0, mk(3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 1'b1));
    cfgWrite(2'd1, 4'd0, 16'd5);
    cfgWrite(2'd0, 4'd9, mk(3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 1'b1));
    run(20);
    phase = "R6";
    run(3);
    cfgWrite(2'd2, 4'd0, 16'd1);
    run(30);
    phase = "R4";
    run(30);
    phase = "R10";
    cfgWrite(2'd0, 4'd3, mk(3'd1, 3'd1, 3'd1, 3'd1, 3'd7, 1'b1));
    cfgWrite(2'd1, 4'd0, 16'd3);
    cfgWrite(2'd0, 4'd10, mk(3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0));
    phase = "R6";
    cfgWrite(2'd2, 4'd0, 16'd0);
    run(30);
    phase = "R12"; runEn = 0;
    run(10);
    phase = "R5"; runEn = 1;
    cfgWrite(2'd2, 4'd0, 16'd1);
    run(30);
    phase = "R8"; feed = 0;
    run(20);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule